// File: doc/BRIEF.md
# Serial Peripheral Interrupt Status and Enable Unit

This block gathers the interrupt sources of a serial peripheral into a single level interrupt line. The receive and transmit logic next to it report conditions in one of two ways. Single-cycle pulses mark one-off events such as an overrun or an underrun. Level inputs mark conditions that hold for as long as the receive queue is non-empty or full. Each source sets its own bit in a 32-bit status register.

Software reaches three registers over a simple word-addressed register port: a global enable, the status register and a per-bit enable mask. Software clears a status bit by writing a one to it, because a write to the status register inverts every bit written as one. The interrupt line is registered. It is high when at least one status bit is also enabled in the mask and the global enable bit is set. A soft-clear input returns all three registers to zero.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, reads of the global enable (byte offset 0x1C), status (0x20) and mask (0x28) registers return 0, and `irq_o` is low.
- R2: The global enable register at 0x1C stores only bit 31. A read returns that bit in position 31 and 0 in bits 30..0.
- R3: The mask register at 0x28 stores all 32 written bits and returns them on read.
- R4: A write to the status register at 0x20 replaces its contents with the old contents XOR the written data, so each written 1 inverts its bit.
- R5: A pulse on `rx_ovr_i` sets status bit 5, `tx_half_i` sets bit 6, `tx_udr_i` sets bit 3 and `tx_empty_i` sets bit 2, on the next clock edge.
- R6: While `rx_nempty_i` is high, status bit 8 is set on every clock edge. While `rx_full_i` is high, status bit 4 is set on every clock edge. Either bit returns to 1 one cycle after software clears it, if its level input is still high.
- R7: When a hardware source and a status write target the same bit in the same cycle, the bit ends up 1.
- R8: `irq_o` takes the value ((status AND mask) != 0) AND global enable bit 31, computed from the register values of the previous cycle. It therefore follows a register change by one clock.
- R9: A `soft_clr_i` cycle clears all three registers, and takes priority over writes and hardware sources in that same cycle.
- R10: Writes to any other word offset change none of the three registers, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Synchronous clear of all registers |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| rx_ovr_i | input | 1 | Receive overrun pulse |
| tx_half_i | input | 1 | Transmit half-empty pulse |
| tx_udr_i | input | 1 | Transmit underrun pulse |
| tx_empty_i | input | 1 | Transmit empty pulse |
| rx_nempty_i | input | 1 | Receive queue non-empty level |
| rx_full_i | input | 1 | Receive queue full level |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets the cycle in which a status write meets a hardware set on the same bit. A design that let the write win would drop an event that arrived exactly as software was clearing it. It clears a status bit while its level input is still high and checks that the bit comes back one cycle later; a design that treated the levels as pulses would leave the bit cleared. Global-enable writes with every bit set must read back only bit 31. Writes to unmapped offsets and a soft clear issued together with writes and events must leave the registers unchanged and zero respectively. `irq_o` is compared every cycle against a model that is one register behind, which catches a line that is combinational or lags by two cycles.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam logic [7:0] OFF_GIE = 8'h1C;
  localparam logic [7:0] OFF_ISR = 8'h20;
  localparam logic [7:0] OFF_IER = 8'h28;

  localparam int unsigned BIT_TX_EMPTY  = 2;
  localparam int unsigned BIT_TX_UDR    = 3;
  localparam int unsigned BIT_RX_FULL   = 4;
  localparam int unsigned BIT_RX_OVR    = 5;
  localparam int unsigned BIT_TX_HALF   = 6;
  localparam int unsigned BIT_RX_NEMPTY = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_ISR,
    SEL_IER
  } reg_sel_e;
endpackage

// File: rtl/spi_irq_regdec.sv
module spi_irq_regdec
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              wr_gie_o,
  output logic              wr_isr_o,
  output logic              wr_ier_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (word == WORD_W'(OFF_GIE >> 2)) sel_o = SEL_GIE;
    else if (word == WORD_W'(OFF_ISR >> 2)) sel_o = SEL_ISR;
    else if (word == WORD_W'(OFF_IER >> 2)) sel_o = SEL_IER;
  end

  assign wr_gie_o = we_i && (sel_o == SEL_GIE);
  assign wr_isr_o = we_i && (sel_o == SEL_ISR);
  assign wr_ier_o = we_i && (sel_o == SEL_IER);

  always_comb begin
    a_one_strobe_r10: assert ($countones({wr_gie_o, wr_isr_o, wr_ier_o}) <= 1);
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              tgl_en_i,
  input  logic [DATA_W-1:0] tgl_i,
  input  logic [DATA_W-1:0] hw_set_i,
  output logic [DATA_W-1:0] st_o
);
  logic [DATA_W-1:0] st_q, st_d;

  // hardware set is OR-ed after the toggle so it wins on a collision
  always_comb begin
    st_d = st_q;
    if (tgl_en_i) st_d = st_d ^ tgl_i;
    st_d = st_d | hw_set_i;
    if (soft_clr_i) st_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  p_hw_set_sticks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_clr_i && (hw_set_i != '0)) |=> ((st_o & $past(hw_set_i)) == $past(hw_set_i)));

  p_toggle_xor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_clr_i && tgl_en_i && (hw_set_i == '0)) |=> (st_o == ($past(st_o) ^ $past(tgl_i))));

  p_soft_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (st_o == '0));

  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_clr_i && !tgl_en_i && (hw_set_i == '0)) |=> $stable(st_o));
endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              wr_gie_i,
  input  logic              wr_ier_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] st_i,
  output logic              gie_o,
  output logic [DATA_W-1:0] ier_o,
  output logic              irq_o
);
  localparam int unsigned GIE_BIT = DATA_W - 1;

  logic              gie_q;
  logic [DATA_W-1:0] ier_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      ier_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= gie_q && ((st_i & ier_q) != '0);
      if (soft_clr_i) begin
        gie_q <= 1'b0;
        ier_q <= '0;
      end else begin
        if (wr_gie_i) gie_q <= wdata_i[GIE_BIT];
        if (wr_ier_i) ier_q <= wdata_i;
      end
    end
  end

  assign gie_o = gie_q;
  assign ier_o = ier_q;
  assign irq_o = irq_q;

  p_irq_needs_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_o));

  p_irq_needs_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(st_i & ier_o) != '0));

  p_ier_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ier_i && !soft_clr_i) |=> (ier_o == $past(wdata_i)));

  p_soft_clear_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (!gie_o && (ier_o == '0)));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_ovr_i,
  input  logic              tx_half_i,
  input  logic              tx_udr_i,
  input  logic              tx_empty_i,
  input  logic              rx_nempty_i,
  input  logic              rx_full_i,
  output logic              irq_o
);
  localparam int unsigned GIE_BIT = DATA_W - 1;

  reg_sel_e          sel;
  logic              wr_gie, wr_isr, wr_ier;
  logic [DATA_W-1:0] hw_set, st, ier;
  logic              gie;

  spi_irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .we_i    (we_i),
    .sel_o   (sel),
    .wr_gie_o(wr_gie),
    .wr_isr_o(wr_isr),
    .wr_ier_o(wr_ier)
  );

  always_comb begin
    hw_set = '0;
    hw_set[BIT_RX_OVR]    = rx_ovr_i;
    hw_set[BIT_TX_HALF]   = tx_half_i;
    hw_set[BIT_TX_UDR]    = tx_udr_i;
    hw_set[BIT_TX_EMPTY]  = tx_empty_i;
    hw_set[BIT_RX_NEMPTY] = rx_nempty_i;
    hw_set[BIT_RX_FULL]   = rx_full_i;
  end

  spi_irq_status #(.DATA_W(DATA_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_clr_i(soft_clr_i),
    .tgl_en_i  (wr_isr),
    .tgl_i     (wdata_i),
    .hw_set_i  (hw_set),
    .st_o      (st)
  );

  spi_irq_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_clr_i(soft_clr_i),
    .wr_gie_i  (wr_gie),
    .wr_ier_i  (wr_ier),
    .wdata_i   (wdata_i),
    .st_i      (st),
    .gie_o     (gie),
    .ier_o     (ier),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_GIE:  rdata_o[GIE_BIT] = gie;
      SEL_ISR:  rdata_o = st;
      SEL_IER:  rdata_o = ier;
      default:  rdata_o = '0;
    endcase
  end

  p_level_reassert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_nempty_i && !soft_clr_i) |=> st[BIT_RX_NEMPTY]);

  p_event_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovr_i && !soft_clr_i) |=> st[BIT_RX_OVR]);
endmodule

// File: tb/spi_irq_ctrl_bench.sv
module spi_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ev = '0;   // [0] ovr bit5, [1] half bit6, [2] udr bit3, [3] empty bit2
  logic        lv_ne = 1'b0, lv_full = 1'b0;
  logic        irq;

  int total = 0, bad = 0;
  bit finished = 0;

  logic        m_gie = 1'b0;
  logic [31:0] m_isr = '0, m_ier = '0;
  logic        m_irq = 1'b0;

  always #4 clk = ~clk;

  spi_irq_ctrl u_spi_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_clr_i(soft_clr),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_ovr_i(ev[0]), .tx_half_i(ev[1]), .tx_udr_i(ev[2]), .tx_empty_i(ev[3]),
    .rx_nempty_i(lv_ne), .rx_full_i(lv_full), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a[7:2])
      6'h07:   return {m_gie, 31'b0};
      6'h08:   return m_isr;
      6'h0A:   return m_ier;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_hw();
    logic [31:0] h = '0;
    h[5] = ev[0]; h[6] = ev[1]; h[3] = ev[2]; h[2] = ev[3];
    h[8] = lv_ne; h[4] = lv_full;
    return h;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at negedge, check outputs before the edge, then advance model
  task automatic cyc(input string tag, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic [3:0] e,
                     input logic ne, input logic fu, input logic sc);
    @(negedge clk);
    we = w; addr = a; wdata = d; ev = e; lv_ne = ne; lv_full = fu; soft_clr = sc;
    #1;
    chk(tag, rdata, m_read(a));
    chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
    @(posedge clk);
    m_irq = m_gie && ((m_isr & m_ier) != 0);
    if (sc) begin
      m_gie = 0; m_isr = '0; m_ier = '0;
    end else begin
      if (w && a[7:2] == 6'h07) m_gie = d[31];
      if (w && a[7:2] == 6'h0A) m_ier = d;
      if (w && a[7:2] == 6'h08) m_isr = m_isr ^ d;
      m_isr = m_isr | m_hw();
    end
  endtask

  task automatic idle_rd(input string tag, input logic [7:0] a);
    cyc(tag, 0, a, 32'h0, 4'h0, lv_ne, lv_full, 0);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle_rd("R1 gie", 8'h1C);
    idle_rd("R1 isr", 8'h20);
    idle_rd("R1 ier", 8'h28);
    // R2 only bit 31 kept
    cyc("R2", 1, 8'h1C, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle_rd("R2 read", 8'h1C);
    chk("R2 literal", rdata, 32'h8000_0000);
    // R3 full mask
    cyc("R3", 1, 8'h28, 32'hA5A5_0F0F, 0, 0, 0, 0);
    idle_rd("R3 read", 8'h28);
    chk("R3 literal", rdata, 32'hA5A5_0F0F);
    // R4 toggle
    cyc("R4", 1, 8'h20, 32'h0000_0101, 0, 0, 0, 0);
    idle_rd("R4 set", 8'h20);
    chk("R4 literal", rdata, 32'h0000_0101);
    cyc("R4", 1, 8'h20, 32'h0000_0001, 0, 0, 0, 0);
    idle_rd("R4 clr", 8'h20);
    chk("R4 literal2", rdata, 32'h0000_0100);
    idle_rd("R8 irq on", 8'h20);
    // R5 events
    cyc("R5", 0, 8'h20, 0, 4'b1111, 0, 0, 0);
    idle_rd("R5 read", 8'h20);
    chk("R5 literal", rdata, 32'h0000_016C);
    // R6 levels re-assert after clear
    cyc("R6", 0, 8'h20, 0, 0, 1, 1, 0);
    cyc("R6", 1, 8'h20, 32'h0000_0110, 0, 1, 1, 0);
    idle_rd("R6 back", 8'h20);
    chk("R6 literal", rdata & 32'h110, 32'h110);
    // R7 collision
    cyc("R7", 1, 8'h20, 32'h0000_0004, 4'b1000, 0, 0, 0);
    idle_rd("R7 read", 8'h20);
    chk("R7 literal", rdata & 32'h4, 32'h4);
    // R10 unmapped
    cyc("R10", 1, 8'h24, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle_rd("R10 read", 8'h24);
    idle_rd("R10 ier", 8'h28);
    cyc("R10", 1, 8'h40, 32'h0000_000A, 0, 0, 0, 0);
    idle_rd("R10 isr", 8'h20);
    // R9 soft clear beats write and events
    cyc("R9", 1, 8'h28, 32'hFFFF_FFFF, 4'b1111, 1, 1, 1);
    idle_rd("R9 gie", 8'h1C);
    idle_rd("R9 isr", 8'h20);
    idle_rd("R9 ier", 8'h28);
    chk("R9 literal", rdata, 32'h0);
    // R8 irq path
    cyc("R8", 1, 8'h28, 32'h0000_0020, 0, 0, 0, 0);
    cyc("R8", 1, 8'h1C, 32'h8000_0000, 0, 0, 0, 0);
    cyc("R8", 0, 8'h20, 0, 4'b0001, 0, 0, 0);
    idle_rd("R8", 8'h20);
    idle_rd("R8 high", 8'h20);
    chk("R8 literal", {31'b0, irq}, 32'h1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  pick = 3'($urandom_range(0, 5));
      logic [7:0]  a;
      logic [31:0] d = $urandom();
      case (pick)
        0: a = 8'h1C; 1: a = 8'h20; 2: a = 8'h28;
        3: a = 8'h24; 4: a = 8'h00; default: a = 8'h2C;
      endcase
      if (pick == 1) d = d & 32'h0000_01FF;
      cyc(pick == 0 ? "R2" : pick == 1 ? "R4" : pick == 2 ? "R3" : "R10",
          ($urandom_range(0, 1) == 1), a, d,
          4'(($urandom_range(0, 7) == 0) ? $urandom() : 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 63) == 0));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule